// File: doc/BRIEF.md
# Key-locked reset watchdog

This block is a countdown watchdog for a power-management device. Software writes a 32-bit timeout as two 16-bit halves and then sets a run bit. The counter loads that value and counts down by one on each qualifying tick of a slow timebase. The timebase is a single-cycle strobe derived from a 32768 Hz clock. When a tick arrives while the count is zero, the watchdog expires. It then either drives a system reset pulse or, when reset generation is off, sets a sticky expiry flag. In both cases the counter reloads.

The configuration registers are write-protected. Writing the 16-bit key 0xE551 to the lock register opens them. Writing any other value closes them again, and the complement of the key is the usual way to do that. Writing the timeout halves while the counter runs acts as a feed: at the next tick the counter takes the new timeout value instead of counting down. Counting happens only while both the module-enable input and the clock-enable input are high.

Top module: `keylock_wdt`

## Requirements
- R1: After reset the block is locked (reading offset 0xA0 returns bit 0 = 1). The timeout halves, the control register, the count, `sys_rst` and `expired` are all zero.
- R2: A write of 0xE551 to offset 0xA0 unlocks the block, and bit 0 of that register reads 0. A write of any other 16-bit value to 0xA0 locks it, and bit 0 reads 1.
- R3: While locked, writes to offsets 0x80, 0x84 and 0x88 are ignored, and reading those offsets still returns the previous contents.
- R4: Reading 0x80 returns the low timeout half and 0x84 the high half. Reading 0x88 returns run in bit 1, reset-enable in bit 3 and the expiry flag in bit 4. Reading 0x8C returns the low half of the live count and 0x90 the high half. `rdata` follows `addr` combinationally.
- R5: A control write that sets bit 1 while run is 0 loads the count with {high, low} on that clock edge.
- R6: The count decrements by one, with borrow across the 16-bit halves, on each edge where `tick`, `mod_en`, `clk_en` and run are all high. Otherwise it holds.
- R7: A qualifying tick that finds the count at zero is an expiry, and it reloads the count from {high, low}. A timeout value L therefore expires on the (L+1)-th tick after the start.
- R8: With reset-enable set, an expiry drives `sys_rst` high for exactly 4 clock cycles, starting in the cycle after the expiring tick, and the expiry flag stays clear.
- R9: With reset-enable clear, an expiry sets the sticky `expired` flag and `sys_rst` stays low. An unlocked control write with bit 4 = 1 clears the flag. If an expiry happens in the same cycle as the clear, the flag is set.
- R10: An unlocked write to 0x80 or 0x84 while running does not change the count at once. The next qualifying tick loads {high, low} instead of decrementing or expiring. A feed write made in the same cycle as an expiring tick does not cancel that expiry.
- R11: Writing the control register with bit 1 = 0 stops the counter, and the count then holds through ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe of the 32768 Hz timebase |
| mod_en | input | 1 | Module enable from the device's enable register |
| clk_en | input | 1 | Work-clock enable for the watchdog |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| sys_rst | output | 1 | System reset pulse |
| expired | output | 1 | Sticky expiry flag |

## Verification
Two functions can fall on the same edge: a register write (a feed, or a flag clear) and the tick that expires the counter. The bench provokes this by raising `wr_en` and `tick` in the same cycle while the count sits at zero. It then judges the outcome against the rules of R9 and R10. The expiry must still fire and the flag must be set. The count must first reload the old timeout and then take the fed value on the following tick. Near-exhaustive sweeps over small timeout values check the expiry tick number and the reset pulse width arithmetically.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LOAD_LO = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_LOAD_HI = 8'h84;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h88;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 8'h8C;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 8'h90;
  localparam logic [ADDR_W-1:0] OFF_LOCK    = 8'hA0;

  localparam int CTRL_RUN_BIT  = 1;
  localparam int CTRL_RST_BIT  = 3;
  localparam int CTRL_FLAG_BIT = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD_LO,
    SEL_LOAD_HI,
    SEL_CTRL,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_LOCK
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_LOAD_LO: s = SEL_LOAD_LO;
      OFF_LOAD_HI: s = SEL_LOAD_HI;
      OFF_CTRL:    s = SEL_CTRL;
      OFF_CNT_LO:  s = SEL_CNT_LO;
      OFF_CNT_HI:  s = SEL_CNT_HI;
      OFF_LOCK:    s = SEL_LOCK;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
  import kwdt_pkg::*;
#(
  parameter int              HALF_W = 16,
  parameter logic [HALF_W-1:0] KEY  = 16'hE551,
  localparam int             CNT_W  = 2 * HALF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                expire_evt,
  input  logic [CNT_W-1:0]    count,
  output logic [HALF_W-1:0]   rdata,
  output logic [CNT_W-1:0]    load_val,
  output logic                run,
  output logic                rst_en,
  output logic                start_evt,
  output logic                feed_evt,
  output logic                expired
);

  logic [HALF_W-1:0] lo_q, hi_q;
  logic              run_q, rsten_q, flag_q, locked_q;
  reg_sel_e          sel;

  // named write events, qualified by the lock
  logic wr_lock, key_hit, cfg_wr_lo, cfg_wr_hi, cfg_wr_ctrl;
  logic flag_set, flag_clr;

  assign sel         = decode_addr(addr);
  assign wr_lock     = wr_en && (sel == SEL_LOCK);
  assign key_hit     = (wdata == KEY);
  assign cfg_wr_lo   = wr_en && (sel == SEL_LOAD_LO) && !locked_q;
  assign cfg_wr_hi   = wr_en && (sel == SEL_LOAD_HI) && !locked_q;
  assign cfg_wr_ctrl = wr_en && (sel == SEL_CTRL) && !locked_q;

  assign start_evt = cfg_wr_ctrl && wdata[CTRL_RUN_BIT] && !run_q;
  assign feed_evt  = (cfg_wr_lo || cfg_wr_hi) && run_q;
  assign flag_set  = expire_evt && !rsten_q;
  assign flag_clr  = cfg_wr_ctrl && wdata[CTRL_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      lo_q     <= '0;
      hi_q     <= '0;
      run_q    <= 1'b0;
      rsten_q  <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_lock)   locked_q <= !key_hit;
      if (cfg_wr_lo) lo_q     <= wdata;
      if (cfg_wr_hi) hi_q     <= wdata;
      if (cfg_wr_ctrl) begin
        run_q   <= wdata[CTRL_RUN_BIT];
        rsten_q <= wdata[CTRL_RST_BIT];
      end
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LOAD_LO: rdata = lo_q;
      SEL_LOAD_HI: rdata = hi_q;
      SEL_CTRL: begin
        rdata[CTRL_RUN_BIT]  = run_q;
        rdata[CTRL_RST_BIT]  = rsten_q;
        rdata[CTRL_FLAG_BIT] = flag_q;
      end
      SEL_CNT_LO:  rdata = count[HALF_W-1:0];
      SEL_CNT_HI:  rdata = count[CNT_W-1:HALF_W];
      SEL_LOCK:    rdata[0] = locked_q;
      default:     rdata = '0;
    endcase
  end

  assign load_val = {hi_q, lo_q};
  assign run      = run_q;
  assign rst_en   = rsten_q;
  assign expired  = flag_q;

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == OFF_LOCK) && (wdata == KEY) |=> !locked_q);

  a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == OFF_LOCK) && (wdata != KEY) |=> locked_q);

  a_r3_load_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && !wr_lock |=> $stable({hi_q, lo_q}));

  a_r3_ctrl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && wr_en && (addr == OFF_CTRL) |=> $stable({run_q, rsten_q}));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(wr_en && (addr == OFF_CTRL) && !locked_q) |=> flag_q);

  a_r9_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && !rsten_q |=> flag_q);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ok,
  input  logic             start,
  input  logic             feed,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt
);

  logic [CNT_W-1:0] count_q;
  logic             pend_q;
  logic             step_evt, reload_evt;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  assign reload_evt = tick_ok && !start && pend_q;
  assign expire_evt = tick_ok && !start && !pend_q && (count_q == '0);
  assign step_evt   = tick_ok && !start && !pend_q && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else if (start) begin
      count_q <= load_val;
      pend_q  <= 1'b0;
    end else begin
      if (reload_evt || expire_evt) count_q <= load_val;
      else if (step_evt)            count_q <= step_down(count_q);
      if (feed)         pend_q <= 1'b1;
      else if (tick_ok) pend_q <= 1'b0;
    end
  end

  assign count = count_q;

  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count_q == $past(load_val));

  a_r6_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ok && !start |=> $stable(count_q));

  a_r6_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ok && !start && !pend_q && (count_q != '0)
      |=> count_q == CNT_W'($past(count_q) - CNT_W'(1)));

  a_r7_expiry_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> count_q == $past(load_val));

  a_r10_feed_arms: assert property (@(posedge clk) disable iff (!rst_n)
    feed && !start |=> pend_q);

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int RST_CYCLES = 4,
  localparam int PW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  logic [PW-1:0] left_q;
  logic [PW-1:0] hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PW'(RST_CYCLES);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign pulse = (left_q != '0);

  // checker-side length of the current high run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_len_q <= '0;
    else if (fire || !pulse)          hi_len_q <= '0;
    else if (hi_len_q != {PW{1'b1}})  hi_len_q <= hi_len_q + PW'(1);
  end

  a_r8_rises_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);

  a_r8_bounded_width: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (hi_len_q < PW'(RST_CYCLES)));

  a_r8_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !$rose(pulse));

endmodule

// File: rtl/keylock_wdt.sv
module keylock_wdt
  import kwdt_pkg::*;
#(
  parameter int                HALF_W     = 16,
  parameter logic [HALF_W-1:0] KEY        = 16'hE551,
  parameter int                RST_CYCLES = 4,
  localparam int               CNT_W      = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mod_en,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata,
  output logic              sys_rst,
  output logic              expired
);

  logic [CNT_W-1:0] load_val, count;
  logic             run, rst_en, start_evt, feed_evt, expire_evt;
  logic             tick_ok, fire_rst;

  assign tick_ok  = tick && mod_en && clk_en && run;
  assign fire_rst = expire_evt && rst_en;

  kwdt_regfile #(.HALF_W(HALF_W), .KEY(KEY)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .expire_evt (expire_evt),
    .count      (count),
    .rdata      (rdata),
    .load_val   (load_val),
    .run        (run),
    .rst_en     (rst_en),
    .start_evt  (start_evt),
    .feed_evt   (feed_evt),
    .expired    (expired)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ok    (tick_ok),
    .start      (start_evt),
    .feed       (feed_evt),
    .load_val   (load_val),
    .count      (count),
    .expire_evt (expire_evt)
  );

  kwdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_rst),
    .pulse (sys_rst)
  );

  a_r8_reset_not_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && rst_en |=> sys_rst);

  a_r6_gated_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && clk_en) |-> !tick_ok);

endmodule

// File: tb/keylock_wdt_test.sv
module keylock_wdt_test;

  localparam logic [15:0] KEYV = 16'hE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, mod_en = 1'b1, clk_en = 1'b1, wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        sys_rst, expired;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keylock_wdt uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_en(mod_en), .clk_en(clk_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sys_rst(sys_rst), .expired(expired)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_cnt(output longint c);
    logic [15:0] l, h;
    rd(8'h8C, l);
    rd(8'h90, h);
    c = {h, l};
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    longint c;
    int w;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'hA0, d); chk("R1 locked", d[0], 1);
    rd(8'h88, d); chk("R1 ctrl", d, 0);
    rd(8'h80, d); chk("R1 load lo", d, 0);
    rd(8'h84, d); chk("R1 load hi", d, 0);
    rd_cnt(c);    chk("R1 count", c, 0);
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 expired", expired, 0);

    // R3 writes ignored while locked
    wr(8'h80, 16'h1234); rd(8'h80, d); chk("R3 lo locked", d, 0);
    wr(8'h84, 16'h5678); rd(8'h84, d); chk("R3 hi locked", d, 0);
    wr(8'h88, 16'h000A); rd(8'h88, d); chk("R3 ctrl locked", d, 0);

    // R2 key opens, any other value closes
    foreach (d[i]) ; // no-op keeps d declared use simple
    begin
      logic [15:0] others [6] = '{16'h0000, 16'hE550, 16'hE553, 16'h1AAE, 16'hFFFF, 16'h51E5};
      for (int i = 0; i < 6; i++) begin
        wr(8'hA0, KEYV);      rd(8'hA0, d); chk("R2 key opens", d[0], 0);
        wr(8'hA0, others[i]); rd(8'hA0, d); chk("R2 value closes", d[0], 1);
      end
    end
    wr(8'hA0, KEYV);

    // R4 readback of halves
    wr(8'h80, 16'hBEEF); wr(8'h84, 16'h0012);
    rd(8'h80, d); chk("R4 lo", d, 16'hBEEF);
    rd(8'h84, d); chk("R4 hi", d, 16'h0012);

    // R5 R6 borrow across halves
    wr(8'h80, 16'h0000); wr(8'h84, 16'h0001);
    wr(8'h88, 16'h0002);
    rd_cnt(c); chk("R5 start load", c, 32'h0001_0000);
    pulse_tick();
    rd_cnt(c); chk("R6 borrow", c, 32'h0000_FFFF);
    wr(8'h88, 16'h0010);
    wr(8'h84, 16'h0000);

    // R7 R9 expiry sweep with reset disabled
    for (int L = 0; L <= 5; L++) begin
      wr(8'h80, 16'(L));
      wr(8'h88, 16'h0002);
      rd_cnt(c); chk("R5 start", c, L);
      for (int k = 1; k <= L + 1; k++) begin
        pulse_tick();
        rd_cnt(c);
        chk("R7 count", c, (k <= L) ? (L - k) : L);
        chk("R9 flag", expired, (k == L + 1) ? 1 : 0);
        chk("R9 no reset", sys_rst, 0);
      end
      wr(8'h88, 16'h0010);
      chk("R9 clear", expired, 0);
    end

    // R6 enable gating, R11 stop
    wr(8'h80, 16'd100);
    wr(8'h88, 16'h0002);
    for (int m = 0; m < 4; m++) begin
      mod_en = m[1]; clk_en = m[0];
      pulse_tick();
      rd_cnt(c); chk("R6 gating", c, (m == 3) ? 99 : 100);
    end
    mod_en = 1'b1; clk_en = 1'b1;
    wr(8'h88, 16'h0000);
    pulse_tick();
    rd_cnt(c); chk("R11 stopped holds", c, 99);

    // R8 reset pulse sweep
    for (int L = 0; L <= 2; L++) begin
      wr(8'h88, 16'h0000);
      wr(8'h80, 16'(L));
      wr(8'h88, 16'h000A);
      for (int k = 1; k <= L; k++) begin
        pulse_tick();
        chk("R8 quiet before", sys_rst, 0);
      end
      pulse_tick();
      w = 0;
      while (sys_rst && w < 20) begin
        w++;
        @(negedge clk);
      end
      chk("R8 width", w, 4);
      chk("R8 flag clear", expired, 0);
    end

    // R10 feed while running
    wr(8'h88, 16'h0000);
    wr(8'h80, 16'd10);
    wr(8'h88, 16'h0002);
    repeat (3) pulse_tick();
    rd_cnt(c); chk("R6 three ticks", c, 7);
    wr(8'h80, 16'd20);
    rd_cnt(c); chk("R10 no immediate load", c, 7);
    pulse_tick();
    rd_cnt(c); chk("R10 feed reload", c, 20);

    // R10 R9 feed in the same cycle as an expiring tick
    wr(8'h88, 16'h0010);
    wr(8'h80, 16'd2);
    wr(8'h88, 16'h0002);
    repeat (2) pulse_tick();
    rd_cnt(c); chk("R7 at zero", c, 0);
    @(negedge clk);
    addr = 8'h80; wdata = 16'd5; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R10 expiry kept", expired, 1);
    rd_cnt(c); chk("R10 old reload", c, 2);
    pulse_tick();
    rd_cnt(c); chk("R10 pending feed", c, 5);

    // R9 set wins over clear in the same cycle
    wr(8'h88, 16'h0010);
    wr(8'h80, 16'd0);
    wr(8'h88, 16'h0002);
    @(negedge clk);
    addr = 8'h88; wdata = 16'h0012; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R9 set beats clear", expired, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule